// File: doc/BRIEF.md
# Event Word Assembler with Routing Capture

This block builds one 16-bit event word for each accepted event and sends it out over a request/grant/strobe/acknowledge bus. During a gate interval it watches ten routing lines. A routing bit is recorded if its line is high on any clock cycle while the gate is open, whether for one cycle or for the whole interval. When the gate ends, a load pulse writes one word into an output register. That word holds the 3-bit channel number, the ten recorded routing bits and a 3-bit module identifier that comes from static switches.

Loading the register raises an output-full flag. While the flag is up, the block requests the bus. Once the grant arrives, it drives the word with a strobe and holds it until the acknowledge. After the acknowledge it drops the request, and the full flag clears. A load that arrives while the register is still full is refused: the stored word is kept and an overrun flag is raised. The overrun flag stays up until the next transfer completes.

Top module: `evw_assembler`

## Requirements
- R1: After reset, out_full, overrun, bus_req and bus_strobe are 0 and bus_data is all zeros.
- R2: A routing bit is recorded if its input is high on at least one rising clock edge while gate is high. Once recorded, it stays set until the next gate opens.
- R3: The recorded routing bits are cleared on the first cycle of each gate interval, so bits never carry over from one event to the next. Routing activity while gate is low has no effect.
- R4: The transmitted word has the channel number in bits 2:0, routing input k in bit 3+k (input 0 in bit 3, input 9 in bit 12), and the module identifier in bits 15:13. Channel and module identifier are taken on the cycle of the load pulse.
- R5: A load while out_full is 0 stores the word and sets out_full on the next cycle.
- R6: While out_full is set, bus_req is raised. bus_strobe rises on the cycle after bus_grant is seen with bus_req high. bus_req stays high through the strobe.
- R7: bus_data equals the stored word while bus_strobe is high and stays stable until bus_ack. At all other times bus_data is zero.
- R8: A load while out_full is 1 leaves the stored word unchanged and sets overrun. overrun stays set until a transfer completes, which clears it. If a refused load and a completing acknowledge fall on the same cycle, overrun ends up set.
- R9: On the cycle after bus_ack is seen during the strobe, bus_req, bus_strobe and out_full are all 0. No new request is raised until bus_ack has returned low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate | input | 1 | Gate interval, high while the event is being gated |
| load | input | 1 | Single-cycle pulse at the start of the clear phase after the gate |
| chan | input | 3 | Binary number of the accepted channel |
| route | input | 10 | Routing lines |
| mod_id | input | 3 | Module identifier from static switches |
| bus_grant | input | 1 | Bus access granted |
| bus_ack | input | 1 | Receiver acknowledges the data word |
| bus_req | output | 1 | Bus access request |
| bus_strobe | output | 1 | Data valid strobe |
| bus_data | output | 16 | Event word, zero outside the strobe |
| out_full | output | 1 | Output register holds an untransmitted word |
| overrun | output | 1 | A load was refused because the register was full |

## Verification
The assertions assume that all inputs are synchronous to clk, that load is pulsed only while gate is low, and that bus_grant stays high until bus_ack has been given during the strobe. The stimulus respects all three. Every load comes at least one cycle after gate falls, grant is held through to the acknowledge, and ack is raised only once the strobe is seen. Within those limits, random gate lengths, sparse routing patterns and random channel and module values are mixed with directed cases. The directed cases cover a single-cycle routing pulse, routing noise outside the gate, a refused load, a refused load on the acknowledge cycle, and an acknowledge held high across a new load.

// File: rtl/evw_pkg.sv
package evw_pkg;
    localparam int CHAN_W  = 3;
    localparam int ROUTE_N = 10;
    localparam int MOD_W   = 3;
    localparam int WORD_W  = CHAN_W + ROUTE_N + MOD_W;

    typedef struct packed {
        logic [MOD_W-1:0]   mod_id;
        logic [ROUTE_N-1:0] route;
        logic [CHAN_W-1:0]  chan;
    } evt_word_t;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_REQ,
        BUS_SEND,
        BUS_RELEASE
    } bus_state_t;

    function automatic evt_word_t pack_word(
        input logic [CHAN_W-1:0]  c,
        input logic [ROUTE_N-1:0] r,
        input logic [MOD_W-1:0]   m
    );
        evt_word_t w;
        w.chan   = c;
        w.route  = r;
        w.mod_id = m;
        return w;
    endfunction
endpackage

// File: rtl/evw_route_capture.sv
module evw_route_capture
    import evw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               gate,
    input  logic [ROUTE_N-1:0] route,
    output logic [ROUTE_N-1:0] seen
);
    logic gate_q;
    logic gate_open;

    always_ff @(posedge clk) begin
        if (rst) gate_q <= 1'b0;
        else     gate_q <= gate;
    end

    assign gate_open = gate & ~gate_q;

    for (genvar i = 0; i < ROUTE_N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)            seen[i] <= 1'b0;
            else if (gate_open) seen[i] <= route[i];
            else if (gate)      seen[i] <= seen[i] | route[i];
        end

        // R2
        route_hit_chk: assert property (@(posedge clk) disable iff (rst)
            (gate && route[i]) |=> seen[i]);
    end

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !gate |=> $stable(seen));

    // R3
    open_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (gate_open && route == '0) |=> seen == '0);
endmodule

// File: rtl/evw_word_register.sv
module evw_word_register
    import evw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               done,
    input  logic [CHAN_W-1:0]  chan,
    input  logic [ROUTE_N-1:0] seen,
    input  logic [MOD_W-1:0]   mod_id,
    output evt_word_t          word,
    output logic               full,
    output logic               overrun
);
    logic accept;
    logic refuse;

    assign accept = load & ~full;
    assign refuse = load & full;

    always_ff @(posedge clk) begin
        if (rst) begin
            word    <= '0;
            full    <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (accept) begin
                word <= pack_word(chan, seen, mod_id);
                full <= 1'b1;
            end else if (done) begin
                full <= 1'b0;
            end
            if (refuse)    overrun <= 1'b1;
            else if (done) overrun <= 1'b0;
        end
    end

    // R5
    full_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(full) |-> $past(load));

    // R8
    refuse_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (load && full) |=> (overrun && word == $past(word)));

    // R8
    overrun_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(load && full));
endmodule

// File: rtl/evw_bus_handshake.sv
module evw_bus_handshake
    import evw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              full,
    input  evt_word_t         word,
    input  logic              grant,
    input  logic              ack,
    output logic              req,
    output logic              strobe,
    output logic [WORD_W-1:0] data,
    output logic              done
);
    bus_state_t state, state_n;

    always_comb begin
        state_n = state;
        unique case (state)
            BUS_IDLE:    if (full)  state_n = BUS_REQ;
            BUS_REQ:     if (grant) state_n = BUS_SEND;
            BUS_SEND:    if (ack)   state_n = BUS_RELEASE;
            BUS_RELEASE: if (!ack)  state_n = BUS_IDLE;
            default:                state_n = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= BUS_IDLE;
        else     state <= state_n;
    end

    assign req    = (state == BUS_REQ) || (state == BUS_SEND);
    assign strobe = (state == BUS_SEND);
    assign done   = strobe & ack;
    assign data   = strobe ? word : '0;

    // R6
    strobe_full_chk: assert property (@(posedge clk) disable iff (rst)
        strobe |-> (full && req));

    // R7
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && !ack) |=> (strobe && $stable(data)));

    // R9
    ack_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (strobe && ack) |=> (!req && !full));

    // R9
    release_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (state == BUS_RELEASE && ack) |=> !req);
endmodule

// File: rtl/evw_assembler.sv
module evw_assembler
    import evw_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               gate,
    input  logic               load,
    input  logic [CHAN_W-1:0]  chan,
    input  logic [ROUTE_N-1:0] route,
    input  logic [MOD_W-1:0]   mod_id,
    input  logic               bus_grant,
    input  logic               bus_ack,
    output logic               bus_req,
    output logic               bus_strobe,
    output logic [WORD_W-1:0]  bus_data,
    output logic               out_full,
    output logic               overrun
);
    logic [ROUTE_N-1:0] seen;
    evt_word_t          word;
    logic               done;

    evw_route_capture u_capture (
        .clk   (clk),
        .rst   (rst),
        .gate  (gate),
        .route (route),
        .seen  (seen)
    );

    evw_word_register u_register (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .done    (done),
        .chan    (chan),
        .seen    (seen),
        .mod_id  (mod_id),
        .word    (word),
        .full    (out_full),
        .overrun (overrun)
    );

    evw_bus_handshake u_bus (
        .clk    (clk),
        .rst    (rst),
        .full   (out_full),
        .word   (word),
        .grant  (bus_grant),
        .ack    (bus_ack),
        .req    (bus_req),
        .strobe (bus_strobe),
        .data   (bus_data),
        .done   (done)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (!out_full && !overrun && !bus_req && !bus_strobe));
endmodule

// File: tb/evw_assembler_test.sv
module evw_assembler_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gate = 1'b0, load = 1'b0;
    logic [2:0]  chan = '0, mod_id = '0;
    logic [9:0]  route = '0;
    logic        bus_grant = 1'b0, bus_ack = 1'b0;
    logic        bus_req, bus_strobe, out_full, overrun;
    logic [15:0] bus_data;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    evw_assembler uut (
        .clk(clk), .rst(rst), .gate(gate), .load(load), .chan(chan),
        .route(route), .mod_id(mod_id), .bus_grant(bus_grant),
        .bus_ack(bus_ack), .bus_req(bus_req), .bus_strobe(bus_strobe),
        .bus_data(bus_data), .out_full(out_full), .overrun(overrun)
    );

    function automatic logic [15:0] exp_word(logic [2:0] c, logic [9:0] r, logic [2:0] m);
        return {m, r, c};
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // optional noise cycle with gate low, then n gated cycles
    task automatic run_gate(int n, bit noise, output logic [9:0] acc);
        acc = '0;
        if (noise) begin
            @(negedge clk); gate = 1'b0; route = 10'($urandom);
        end
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            gate  = 1'b1;
            route = 10'($urandom) & 10'($urandom) & 10'($urandom);
            acc  |= route;
        end
        @(negedge clk); gate = 1'b0; route = 10'($urandom);
    endtask

    task automatic do_load(logic [2:0] c, logic [2:0] m);
        @(negedge clk); load = 1'b1; chan = c; mod_id = m; route = 10'($urandom);
        @(negedge clk); load = 1'b0; chan = 3'($urandom); mod_id = 3'($urandom);
    endtask

    task automatic wait_req();
        int t = 0;
        while (!bus_req && t < 20) begin @(negedge clk); t++; end
        chk("R6 request raised", bus_req, 1'b1);
    endtask

    task automatic transmit(logic [15:0] exp);
        int d;
        wait_req();
        d = $urandom_range(0, 3);
        for (int i = 0; i < d; i++) begin
            chk("R7 data zero before grant", bus_data, 16'h0);
            @(negedge clk);
        end
        chk("R6 no strobe before grant", bus_strobe, 1'b0);
        bus_grant = 1'b1;
        @(negedge clk);
        chk("R6 strobe after grant", bus_strobe, 1'b1);
        chk("R4 word layout", bus_data, exp);
        d = $urandom_range(0, 3);
        for (int i = 0; i < d; i++) begin
            @(negedge clk);
            chk("R7 data stable", bus_data, exp);
            chk("R6 request held", bus_req, 1'b1);
        end
        bus_ack = 1'b1;
        @(negedge clk);
        chk("R9 request dropped", bus_req, 1'b0);
        chk("R9 strobe dropped", bus_strobe, 1'b0);
        chk("R9 full cleared", out_full, 1'b0);
        chk("R7 data zero after ack", bus_data, 16'h0);
        bus_ack = 1'b0; bus_grant = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        logic [9:0]  acc, acc2;
        logic [2:0]  c, m;
        logic [15:0] wa, wb;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk("R1 full", out_full, 1'b0);
        chk("R1 overrun", overrun, 1'b0);
        chk("R1 req", bus_req, 1'b0);
        chk("R1 strobe", bus_strobe, 1'b0);
        chk("R1 data", bus_data, 16'h0);

        // random events: R2 R3 R4 R5
        for (int k = 0; k < 40; k++) begin
            run_gate($urandom_range(1, 6), 1'b1, acc);
            c = 3'($urandom); m = 3'($urandom);
            do_load(c, m);
            chk("R5 full after load", out_full, 1'b1);
            transmit(exp_word(c, acc, m));
        end

        // R2: single-cycle pulse on input 0 lands in bit 3
        @(negedge clk); gate = 1'b1; route = '0;
        @(negedge clk); route = 10'h001;
        @(negedge clk); route = '0;
        @(negedge clk); gate = 1'b0;
        do_load(3'd5, 3'd2);
        transmit(exp_word(3'd5, 10'h001, 3'd2));

        // R3: all-ones event, then noise outside gate, then quiet gate
        @(negedge clk); gate = 1'b1; route = 10'h3FF;
        @(negedge clk); gate = 1'b0;
        do_load(3'd7, 3'd7);
        transmit(16'hFFFF);
        @(negedge clk); route = 10'h3FF;
        @(negedge clk); gate = 1'b1; route = '0;
        @(negedge clk); gate = 1'b0; route = 10'h3FF;
        @(negedge clk); route = 10'h3FF;
        do_load(3'd1, 3'd4);
        transmit(exp_word(3'd1, 10'h000, 3'd4));

        // R8: refused load keeps first word
        run_gate(3, 1'b0, acc);
        wa = exp_word(3'd3, acc, 3'd6);
        do_load(3'd3, 3'd6);
        run_gate(2, 1'b0, acc2);
        do_load(3'd4, 3'd1);
        chk("R8 overrun set", overrun, 1'b1);
        chk("R8 still full", out_full, 1'b1);
        transmit(wa);
        chk("R8 overrun cleared", overrun, 1'b0);

        // R8: refused load on the acknowledge cycle leaves overrun set
        run_gate(2, 1'b0, acc);
        do_load(3'd2, 3'd3);
        wait_req();
        bus_grant = 1'b1;
        @(negedge clk);
        chk("R4 word before ack", bus_data, exp_word(3'd2, acc, 3'd3));
        bus_ack = 1'b1; load = 1'b1; chan = 3'd6;
        @(negedge clk);
        load = 1'b0; bus_ack = 1'b0; bus_grant = 1'b0;
        chk("R8 set wins full", out_full, 1'b0);
        chk("R8 set wins overrun", overrun, 1'b1);
        run_gate(2, 1'b0, acc);
        do_load(3'd0, 3'd5);
        transmit(exp_word(3'd0, acc, 3'd5));
        chk("R8 overrun cleared again", overrun, 1'b0);

        // R9: ack held high blocks the next request
        run_gate(2, 1'b0, acc);
        do_load(3'd6, 3'd1);
        wait_req();
        bus_grant = 1'b1;
        @(negedge clk);
        bus_ack = 1'b1;
        @(negedge clk);
        bus_grant = 1'b0;
        run_gate(2, 1'b0, acc2);
        wb = exp_word(3'd7, acc2, 3'd0);
        do_load(3'd7, 3'd0);
        for (int i = 0; i < 4; i++) begin
            chk("R9 no request while ack high", bus_req, 1'b0);
            chk("R5 full during held ack", out_full, 1'b1);
            @(negedge clk);
        end
        bus_ack = 1'b0;
        transmit(wb);

        report();
    end
endmodule